// File: doc/BRIEF.md
# Dual-Channel High/Low Count Pulse Generator

This block produces two independent pulse-width-modulated outputs. Each channel's waveform is set by two tick counts: a high time and a low time. The high time is played first and the low time second, and the pair repeats. Each channel has a four-way choice of clock-enable input, and a 7-bit prescaler stretches every count to (prescaler + 1) selected ticks. There is no polarity control. Software produces an inverted waveform by exchanging the two counts.

All configuration sits in three 32-bit registers on a simple synchronous bus. There is one count register per channel and one shared control word. A channel runs only while both its output-enable bit and its clock-gate bit are set in the control word. Clearing either bit drives the output low on the next clock, even in the middle of a period. New counts and a new prescaler are picked up at the next period boundary, so a running waveform is never cut short. Setting the enable bit again restarts the channel at the start of a high phase.

Top module: `twin_pwm`

## Requirements
- R1: Byte offset 0x0 holds channel 0's count register, 0x4 holds channel 1's, and 0x8 holds the control word. A read strobe returns the addressed register on `bus_rdata` one clock later. Every bit reads back exactly as written. When a read and a write hit the same register in one cycle, the read returns the value from before the write. Offset 0xC, and any address with nonzero bits [1:0], reads zero and ignores writes.
- R2: Reset, synchronous and active high, clears every register to zero and holds both outputs low.
- R3: In a count register, bits [31:16] hold the high count and bits [15:0] hold the low count. While a channel runs, its output is high for the high count and then low for the low count, repeating. Rising edge to rising edge is (high + low) counts.
- R4: The prescaler field sits at control bits [14:8] for channel 0 and [22:16] for channel 1. One count lasts (prescaler + 1) ticks of the selected input.
- R5: The source-select field sits at control bits [5:4] for channel 0 and [7:6] for channel 1. Its value N picks `tick_in[N]` as the channel's tick.
- R6: A channel runs only while its enable bit (bit 0 or bit 1) and its gate bit (bit 15 or bit 23) are both set. Otherwise its output is low from the second clock edge after the control write is captured, without waiting for the period to end.
- R7: A low count of zero gives a constant high output. A high count of zero gives a constant low output.
- R8: When both counts are zero on an enabled channel, the output stays low. Nonzero counts written later start the waveform without a re-enable.
- R9: Count and prescaler changes made while a channel runs take effect at the next period boundary. The period in progress completes with the old values.
- R10: When a channel starts running, its output goes high on the clock edge after the control write takes effect. The first high phase lasts the full high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the strobe |
| tick_in | input | 4 | Clock-enable inputs selectable by either channel |
| pwm_out | output | 2 | Channel outputs, bit 0 for channel 0 |

## Verification
Two functions can land in the same cycle. The first pair is a read and a write of the control word. The bench issues both strobes together and expects the old word, then reads again and expects the new one. The second pair is a register write and the channel's own period reload. The bench writes new counts while a high phase is running. It expects the current high and low phases to keep their old lengths, and the following high phase to take the new length.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SEL_W  = 2;
  localparam int NSRC   = 4;
  localparam int NCH    = 2;

  // control word field positions per channel
  function automatic int en_pos(input int ch);
    return ch;
  endfunction

  function automatic int sel_pos(input int ch);
    return 4 + 2 * ch;
  endfunction

  function automatic int div_pos(input int ch);
    return 8 + 8 * ch;
  endfunction

  function automatic int gate_pos(input int ch);
    return 15 + 8 * ch;
  endfunction
endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs #(
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NCH-1:0][DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0]          ctrl_q
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int CTRL_IDX = NCH;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [DATA_W-1:0] rd_mux;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[ch] <= '0;
      else if (bus_wr && aligned && idx == IDX_W'(ch))
        cnt_q[ch] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (bus_wr && aligned && idx == IDX_W'(CTRL_IDX))
      ctrl_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int ch = 0; ch < NCH; ch++)
        if (idx == IDX_W'(ch)) rd_mux = cnt_q[ch];
      if (idx == IDX_W'(CTRL_IDX)) rd_mux = ctrl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/twin_pwm_srcsel.sv
module twin_pwm_srcsel #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel == SEL_W'(i)) tick = tick_in[i];
  end
endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [CNT_W-1:0] hi_cfg,
  input  logic [CNT_W-1:0] lo_cfg,
  output logic             pwm
);
  logic             run_q;
  logic             in_low;
  logic [CNT_W-1:0] act_hi, act_lo, cnt;
  logic [DIV_W-1:0] act_div, pcnt;
  logic [CNT_W:0]   cnt_nx;
  logic             step, idle, end_high, end_low, load;

  always_comb begin
    cnt_nx   = (CNT_W+1)'(cnt) + 1'b1;
    step     = tick && (pcnt == act_div);
    idle     = (act_hi == '0) && (act_lo == '0);
    end_high = !in_low && step && (cnt_nx == (CNT_W+1)'(act_hi));
    end_low  = in_low && step && (cnt_nx == (CNT_W+1)'(act_lo));
    load     = !run_q || idle || (end_high && act_lo == '0) || end_low;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      run_q   <= 1'b0;
      in_low  <= 1'b0;
      act_hi  <= '0;
      act_lo  <= '0;
      act_div <= '0;
      cnt     <= '0;
      pcnt    <= '0;
      pwm     <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        act_hi  <= hi_cfg;
        act_lo  <= lo_cfg;
        act_div <= div_cfg;
        in_low  <= (hi_cfg == '0);
        cnt     <= '0;
        pcnt    <= '0;
        pwm     <= (hi_cfg != '0);
      end else if (end_high) begin
        in_low <= 1'b1;
        cnt    <= '0;
        pcnt   <= '0;
        pwm    <= 1'b0;
      end else if (tick) begin
        pcnt <= step ? '0 : pcnt + 1'b1;
        if (step) cnt <= cnt_nx[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DIV_W  = DIV_W,
  parameter int P_SEL_W  = SEL_W,
  parameter int P_NSRC   = NSRC,
  parameter int P_NCH    = NCH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  input  logic [P_NSRC-1:0]   tick_in,
  output logic [P_NCH-1:0]    pwm_out
);
  logic [P_NCH-1:0][P_DATA_W-1:0] cnt_q;
  logic [P_DATA_W-1:0]            ctrl_q;

  twin_pwm_regs #(.NCH(P_NCH), .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_q(cnt_q), .ctrl_q(ctrl_q)
  );

  for (genvar ch = 0; ch < P_NCH; ch++) begin : g_ch
    localparam int EN_B  = en_pos(ch);
    localparam int SEL_B = sel_pos(ch);
    localparam int DIV_B = div_pos(ch);
    localparam int GT_B  = gate_pos(ch);

    logic               run;
    logic               tick;
    logic [P_SEL_W-1:0] sel;
    logic [P_DIV_W-1:0] div;

    assign run = ctrl_q[EN_B] & ctrl_q[GT_B];
    assign sel = ctrl_q[SEL_B +: P_SEL_W];
    assign div = ctrl_q[DIV_B +: P_DIV_W];

    twin_pwm_srcsel #(.NSRC(P_NSRC), .SEL_W(P_SEL_W)) u_src (
      .tick_in(tick_in), .sel(sel), .tick(tick)
    );

    twin_pwm_chan #(.CNT_W(P_CNT_W), .DIV_W(P_DIV_W)) u_chan (
      .clk(clk), .rst(rst), .run(run), .tick(tick), .div_cfg(div),
      .hi_cfg(cnt_q[ch][2*P_CNT_W-1:P_CNT_W]),
      .lo_cfg(cnt_q[ch][P_CNT_W-1:0]),
      .pwm(pwm_out[ch])
    );
  end
endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk
  import twin_pwm_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_NCH    = NCH
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_rd,
  input logic [P_ADDR_W-1:0] bus_addr,
  input logic [P_DATA_W-1:0] bus_rdata,
  input logic [P_NCH-1:0]    pwm_out,
  input logic [P_DATA_W-1:0] ctrl
);
  // R2: outputs low on the first cycle after reset
  p_reset_low_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pwm_out == '0);

  // R1: control word read returns the value held before the strobe edge
  p_ctrl_readback_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(bus_addr) == P_ADDR_W'(8)) |-> bus_rdata == $past(ctrl));

  // R1: unmapped slot reads zero
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(bus_addr) == P_ADDR_W'(12)) |-> bus_rdata == '0);

  for (genvar ch = 0; ch < P_NCH; ch++) begin : g_chk
    localparam int EN_B = en_pos(ch);
    localparam int GT_B = gate_pos(ch);

    // R6: not running means low on the following edge
    p_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
      !(ctrl[EN_B] && ctrl[GT_B]) |=> !pwm_out[ch]);

    // R6: a rising output needs both enable and gate
    p_rise_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out[ch]) |-> $past(ctrl[EN_B] && ctrl[GT_B]));
  end
endmodule

bind twin_pwm twin_pwm_chk #(.P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W), .P_NCH(P_NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pwm_out(pwm_out), .ctrl(ctrl_q)
);

// File: tb/twin_pwm_test.sv
module twin_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_in = 4'b0001;
  logic [1:0]  pwm_out;
  int          nchk = 0, nbad = 0;
  int unsigned tcnt = 0;

  always #4 clk = ~clk;

  twin_pwm uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .pwm_out(pwm_out)
  );

  // tick sources: every cycle, every 2nd, every 4th, never
  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    tick_in <= {1'b0, (tcnt[1:0] == 2'd3), tcnt[0], 1'b1};
  end

  localparam int NV = 6;
  localparam int V_CH [NV]  = '{0, 0, 0, 0, 0, 1};
  localparam int V_SEL[NV]  = '{0, 0, 0, 1, 2, 0};
  localparam int V_DIV[NV]  = '{0, 0, 2, 1, 0, 3};
  localparam int V_HI [NV]  = '{3, 1, 2, 4, 2, 5};
  localparam int V_LO [NV]  = '{2, 1, 5, 3, 2, 1};
  localparam int TPER [4]   = '{1, 2, 4, 0};

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int ch, input int sel, input int dv,
                                            input bit en, input bit gate);
    logic [31:0] w = '0;
    w[ch] = en;
    w[4 + 2*ch +: 2] = 2'(sel);
    w[8 + 8*ch +: 7] = 7'(dv);
    w[15 + 8*ch] = gate;
    return w;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic bus_rw(input logic [3:0] a, input logic [31:0] wd, output logic [31:0] d);
    bus_addr = a; bus_wdata = wd; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    int n = 0;
    while (pwm_out[ch] != 1'b0 && n < 4000) begin @(negedge clk); n++; end
    while (pwm_out[ch] != 1'b1 && n < 4000) begin @(negedge clk); n++; end
    ok = (n < 4000);
  endtask

  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwm_out[ch] == lvl && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic ones_in(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (pwm_out[ch]) n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int ch, input int hi, input int lo, input int sel, input int dv);
    bus_write(4'h8, 32'h0);
    bus_write(4'(ch * 4), {16'(hi), 16'(lo)});
    bus_write(4'h8, ctrl_word(ch, sel, dv, 1'b1, 1'b1));
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int h, l, n;
    bit ok;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: reset state
    check("R2 outputs", int'(pwm_out), 0);
    bus_read(4'h0, rd); check("R2 count0", int'(rd), 0);
    bus_read(4'h4, rd); check("R2 count1", int'(rd), 0);
    bus_read(4'h8, rd); check("R2 ctrl", int'(rd), 0);

    // R1: readback, collision, unmapped
    bus_write(4'h0, 32'h1234_5678); bus_read(4'h0, rd); check("R1 count0", int'(rd), 32'h1234_5678);
    bus_write(4'h4, 32'hdead_beef); bus_read(4'h4, rd); check("R1 count1", int'(rd), 32'hdead_beef);
    bus_write(4'h8, 32'hf000_0cf0); bus_read(4'h8, rd); check("R1 ctrl", int'(rd), 32'hf000_0cf0);
    bus_rw(4'h8, 32'h0a00_0000, rd); check("R1 collision old", int'(rd), 32'hf000_0cf0);
    bus_read(4'h8, rd); check("R1 collision new", int'(rd), 32'h0a00_0000);
    bus_write(4'hc, 32'hffff_ffff); bus_read(4'hc, rd); check("R1 unmapped", int'(rd), 0);
    bus_write(4'h1, 32'h5555_5555); bus_read(4'h0, rd); check("R1 misaligned write", int'(rd), 32'h1234_5678);
    bus_read(4'h1, rd); check("R1 misaligned read", int'(rd), 0);

    // R3 R4 R5: vector table, steady-state period measured
    for (int v = 0; v < NV; v++) begin
      setup(V_CH[v], V_HI[v], V_LO[v], V_SEL[v], V_DIV[v]);
      wait_rise(V_CH[v], ok);
      wait_rise(V_CH[v], ok);
      run_len(V_CH[v], 1'b1, h);
      run_len(V_CH[v], 1'b0, l);
      check("R3 R4 R5 high time", h, V_HI[v] * (V_DIV[v] + 1) * TPER[V_SEL[v]]);
      check("R3 R4 R5 period", h + l, (V_HI[v] + V_LO[v]) * (V_DIV[v] + 1) * TPER[V_SEL[v]]);
    end

    // R10: start in high phase with full first high count
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd3, 16'd2});
    bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b1));
    check("R10 low before start", int'(pwm_out[0]), 0);
    @(negedge clk);
    check("R10 high at start", int'(pwm_out[0]), 1);
    run_len(0, 1'b1, h);
    check("R10 first high", h, 3);

    // R6: disable mid-period forces low next edge
    wait_rise(0, ok);
    bus_write(4'h8, ctrl_word(0, 0, 0, 1'b0, 1'b1));
    @(negedge clk);
    check("R6 forced low", int'(pwm_out[0]), 0);
    ones_in(0, 30, n); check("R6 gate only", n, 0);
    bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b0));
    ones_in(0, 30, n); check("R6 enable only", n, 0);

    // R7: constant levels
    setup(0, 5, 0, 0, 0);
    repeat (2) @(negedge clk);
    ones_in(0, 40, n); check("R7 constant high", n, 40);
    setup(0, 0, 5, 0, 0);
    ones_in(0, 40, n); check("R7 constant low", n, 0);

    // R8: both zero stays low, then picks up new counts
    setup(0, 0, 0, 0, 0);
    ones_in(0, 40, n); check("R8 both zero", n, 0);
    bus_write(4'h0, {16'd2, 16'd2});
    wait_rise(0, ok); check("R8 picks up", int'(ok), 1);
    run_len(0, 1'b1, h); check("R8 new high", h, 2);

    // R9: change mid-period takes effect at boundary
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd4, 16'd4});
    bus_write(4'h8, ctrl_word(0, 0, 0, 1'b1, 1'b1));
    wait_rise(0, ok);
    bus_write(4'h0, {16'd2, 16'd2});
    run_len(0, 1'b1, h); check("R9 old high kept", h + 1, 4);
    run_len(0, 1'b0, l); check("R9 old low kept", l, 4);
    run_len(0, 1'b1, h); check("R9 new high", h, 2);
    run_len(0, 1'b0, l); check("R9 new low", l, 2);

    // R5: a source that never ticks freezes the high phase
    setup(0, 1, 1, 3, 0);
    repeat (2) @(negedge clk);
    ones_in(0, 40, n); check("R5 frozen source", n, 40);

    bus_write(4'h8, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule